// File: doc/BRIEF.md
# MMU Root Pointer and Translation Control

This block is the register front end of a paged memory management unit. It holds two root pointers, one for user mode and one for supervisor mode, and a 16-bit translation control word. Software reaches all three through one select/strobe register port, and reads come back combinationally. The control word carries the paging enable and the page-size choice. Both are exported to the table-walk logic, together with the page-offset width and the root pointer chosen by the current privilege mode.

When paging is off, the block also acts as the address bypass. The logical address goes straight out as the physical address. The access attributes are either a fixed default set or the attributes of a transparent-window hit, which an external comparator supplies through a hit flag and an attribute bus.

The paging enable is held as a two-state machine.
- States: `MODE_BYPASS` and `MODE_PAGED`.
- Transition `T_ENABLE`: `MODE_BYPASS` to `MODE_PAGED`, on a control-word write with bit 15 set.
- Transition `T_DISABLE`: `MODE_PAGED` to `MODE_BYPASS`, on a control-word write with bit 15 clear.
- Reset forces `MODE_BYPASS` from either state.
- Every other cycle holds the current state.

Top module: `mmu_xlat_ctl`

## Requirements
- R1: `reg_sel` encoding: 0 is the user root, 1 is the supervisor root, 2 is the control word and 3 is unused. A root write (`reg_we`=1, `reg_sel` 0 or 1) stores `reg_wdata[31:9]`. Reading that root returns the stored bits with bits 8..0 as zero.
- R2: Reading the control word returns bit 15 = enable and bit 14 = page size. Bits 31..16 and 13..0 always read zero, whatever data was written to them.
- R3: A control write with `reg_wdata[15]`=1 sets `xlat_en` from the next cycle. A control write with bit 15 = 0 clears it from the next cycle.
- R4: While reset (`rst_n`=0) is applied, `xlat_en` is 0 and both root pointers read zero.
- R5: The page-size bit changes only on a control write, where it takes `reg_wdata[14]`. Reset leaves it unchanged.
- R6: `page_size` equals the page-size bit (0 means 4 KB pages, 1 means 8 KB pages). `page_ofs_bits` is 12 when that bit is 0 and 13 when it is 1.
- R7: `root_ptr` shows the supervisor root when `super_mode`=1 and the user root when it is 0.
- R8: With `xlat_en`=0, `paddr` equals `laddr`. With `xlat_en`=1, `paddr` is zero (the walk logic supplies the translated address).
- R9: Attribute layout is [1:0] cache mode (00 = cachable write-through), [2] write protect, [4:3] user page attributes. With `xlat_en`=0 and `tt_hit`=0, `attr_out` is 5'b00000.
- R10: With `xlat_en`=0 and `tt_hit`=1, `attr_out` equals `tt_attr`. With `xlat_en`=1, `attr_out` is zero regardless of `tt_hit`.
- R11: A write with `reg_sel`=3 changes no register, and reading with `reg_sel`=3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for read and write |
| reg_wdata | input | 32 | Write data (the control word uses bits 15..0) |
| reg_rdata | output | 32 | Combinational read data of the selected register |
| super_mode | input | 1 | Current access is supervisor mode |
| root_ptr | output | 32 | Root pointer for the current mode |
| xlat_en | output | 1 | Paged translation enabled |
| page_size | output | 1 | Page size select, 1 = 8 KB |
| page_ofs_bits | output | 4 | Page offset width in bits |
| laddr | input | 32 | Logical address |
| tt_hit | input | 1 | Transparent window matched |
| tt_attr | input | 5 | Attributes of the matching transparent window |
| paddr | output | 32 | Physical address in bypass |
| attr_out | output | 5 | Access attributes in bypass |

## Verification
Root pointers are written with all-ones and with alternating patterns, so that an alignment mask that is too wide or too narrow shows up in the low bits. The control word is written with every unimplemented bit set and with the enable and page-size bits in all four combinations; this separates leakage from the unimplemented bits from a swapped field. Reset is applied with the page size set and then cleared, so that an accidental reset of that bit is distinguished from correct retention. The bypass path is driven with several addresses under no hit, a hit, and paging on; this tells apart the default attributes, the passed-through window attributes and the suppressed outputs.

// File: rtl/mmu_xctl_pkg.sv
package mmu_xctl_pkg;

    typedef enum logic [1:0] {
        SEL_UROOT = 2'd0,
        SEL_SROOT = 2'd1,
        SEL_XCTL  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        MODE_BYPASS = 1'b0,
        MODE_PAGED  = 1'b1
    } xlat_mode_e;

    typedef enum logic [1:0] {
        CM_WTHRU  = 2'b00,
        CM_CBACK  = 2'b01,
        CM_NC_SER = 2'b10,
        CM_NC     = 2'b11
    } cmode_e;

    typedef struct packed {
        logic [1:0] upa;
        logic       wprot;
        logic [1:0] cmode;
    } xattr_t;

    localparam int ATTR_W = $bits(xattr_t);

    localparam xattr_t DFLT_ATTR = '{upa: 2'b00, wprot: 1'b0, cmode: CM_WTHRU};

endpackage

// File: rtl/mmu_root_regs.sv
module mmu_root_regs #(
    parameter int ADDR_W = 32,
    parameter int ALIGN  = 9,
    parameter int NROOT  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NROOT-1:0]              wr_hit,
    input  logic [ADDR_W-1:0]             wdata,
    output logic [NROOT-1:0][ADDR_W-1:0]  root_q
);
    localparam int HI_W = ADDR_W - ALIGN;

    for (genvar g = 0; g < NROOT; g++) begin : g_root
        logic [HI_W-1:0] hi_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hi_q <= '0;
            end else if (wr_hit[g]) begin
                hi_q <= wdata[ADDR_W-1:ALIGN];
            end
        end

        // only the upper bits are stored; the aligned low bits are constant zero
        assign root_q[g] = {hi_q, {ALIGN{1'b0}}};
    end

endmodule

// File: rtl/mmu_xctl_fsm.sv
module mmu_xctl_fsm
    import mmu_xctl_pkg::*;
#(
    parameter int XCTL_W    = 16,
    parameter int EN_BIT    = 15,
    parameter int PS_BIT    = 14,
    parameter int OFS_SMALL = 12,
    parameter int OFS_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [XCTL_W-1:0] ctl_wdata,
    output logic              xlat_en,
    output logic              page_size,
    output logic [XCTL_W-1:0] ctl_rdata,
    output logic [OFS_W-1:0]  ofs_bits
);
    xlat_mode_e state_q, state_d;
    logic       psize_q;

    // next state: T_ENABLE / T_DISABLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_BYPASS: if (ctl_we &&  ctl_wdata[EN_BIT]) state_d = MODE_PAGED;
            MODE_PAGED:  if (ctl_we && !ctl_wdata[EN_BIT]) state_d = MODE_BYPASS;
            default:     state_d = MODE_BYPASS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MODE_BYPASS;
        end else begin
            state_q <= state_d;
        end
    end

    // page size deliberately has no reset
    always_ff @(posedge clk) begin
        if (ctl_we) begin
            psize_q <= ctl_wdata[PS_BIT];
        end
    end

    always_comb begin
        ctl_rdata         = '0;
        ctl_rdata[EN_BIT] = (state_q == MODE_PAGED);
        ctl_rdata[PS_BIT] = psize_q;
        xlat_en           = (state_q == MODE_PAGED);
        page_size         = psize_q;
        ofs_bits          = psize_q ? OFS_W'(OFS_SMALL + 1) : OFS_W'(OFS_SMALL);
    end

endmodule

// File: rtl/mmu_bypass_path.sv
module mmu_bypass_path
    import mmu_xctl_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              xlat_en,
    input  logic [ADDR_W-1:0] laddr,
    input  logic              tt_hit,
    input  xattr_t            tt_attr,
    output logic [ADDR_W-1:0] paddr,
    output xattr_t            attr
);
    always_comb begin
        if (xlat_en) begin
            paddr = '0;
            attr  = '0;
        end else begin
            paddr = laddr;
            attr  = tt_hit ? tt_attr : DFLT_ATTR;
        end
    end

endmodule

// File: rtl/mmu_xlat_ctl.sv
module mmu_xlat_ctl
    import mmu_xctl_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int ALIGN     = 9,
    parameter int XCTL_W    = 16,
    parameter int EN_BIT    = 15,
    parameter int PS_BIT    = 14,
    parameter int OFS_SMALL = 12,
    parameter int OFS_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              super_mode,
    output logic [ADDR_W-1:0] root_ptr,
    output logic              xlat_en,
    output logic              page_size,
    output logic [OFS_W-1:0]  page_ofs_bits,
    input  logic [ADDR_W-1:0] laddr,
    input  logic              tt_hit,
    input  logic [4:0]        tt_attr,
    output logic [ADDR_W-1:0] paddr,
    output logic [4:0]        attr_out
);
    localparam int NROOT = 2;
    localparam int IDX_U = 0;
    localparam int IDX_S = 1;

    reg_sel_e                     sel;
    logic [NROOT-1:0]             root_wr;
    logic [NROOT-1:0][ADDR_W-1:0] root_q;
    logic                         ctl_we;
    logic [XCTL_W-1:0]            ctl_rdata;
    xattr_t                       attr_s;

    assign sel            = reg_sel_e'(reg_sel);
    assign root_wr[IDX_U] = reg_we && (sel == SEL_UROOT);
    assign root_wr[IDX_S] = reg_we && (sel == SEL_SROOT);
    assign ctl_we         = reg_we && (sel == SEL_XCTL);

    mmu_root_regs #(
        .ADDR_W (ADDR_W),
        .ALIGN  (ALIGN),
        .NROOT  (NROOT)
    ) u_roots (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (root_wr),
        .wdata  (reg_wdata),
        .root_q (root_q)
    );

    mmu_xctl_fsm #(
        .XCTL_W    (XCTL_W),
        .EN_BIT    (EN_BIT),
        .PS_BIT    (PS_BIT),
        .OFS_SMALL (OFS_SMALL),
        .OFS_W     (OFS_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (reg_wdata[XCTL_W-1:0]),
        .xlat_en   (xlat_en),
        .page_size (page_size),
        .ctl_rdata (ctl_rdata),
        .ofs_bits  (page_ofs_bits)
    );

    mmu_bypass_path #(
        .ADDR_W (ADDR_W)
    ) u_byp (
        .xlat_en (xlat_en),
        .laddr   (laddr),
        .tt_hit  (tt_hit),
        .tt_attr (xattr_t'(tt_attr)),
        .paddr   (paddr),
        .attr    (attr_s)
    );

    assign attr_out = attr_s;
    assign root_ptr = super_mode ? root_q[IDX_S] : root_q[IDX_U];

    always_comb begin
        unique case (sel)
            SEL_UROOT: reg_rdata = root_q[IDX_U];
            SEL_SROOT: reg_rdata = root_q[IDX_S];
            SEL_XCTL:  reg_rdata = ADDR_W'(ctl_rdata);
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mmu_xlat_ctl_chk.sv
module mmu_xlat_ctl_chk #(
    parameter int ADDR_W = 32,
    parameter int ALIGN  = 9,
    parameter int EN_BIT = 15,
    parameter int PS_BIT = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [1:0]        reg_sel,
    input logic [ADDR_W-1:0] reg_wdata,
    input logic [ADDR_W-1:0] reg_rdata,
    input logic [ADDR_W-1:0] root_ptr,
    input logic              xlat_en,
    input logic              page_size,
    input logic [ADDR_W-1:0] laddr,
    input logic              tt_hit,
    input logic [4:0]        tt_attr,
    input logic [ADDR_W-1:0] paddr,
    input logic [4:0]        attr_out
);
    // R1
    root_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel < 2'd2) |-> (reg_rdata[ALIGN-1:0] == '0 && root_ptr[ALIGN-1:0] == '0));

    // R2
    ctl_unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd2) |-> (reg_rdata[ADDR_W-1:EN_BIT+1] == '0 && reg_rdata[PS_BIT-1:0] == '0));

    // R3
    enable_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == 2'd2) |=> (xlat_en == $past(reg_wdata[EN_BIT])));

    // R5
    psize_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_sel == 2'd2) |=> $stable(page_size));

    // R8
    bypass_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xlat_en |-> (paddr == laddr));

    // R9
    default_attr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!xlat_en && !tt_hit) |-> (attr_out == 5'b00000));

    // R10
    tt_attr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!xlat_en && tt_hit) |-> (attr_out == tt_attr));

    // R11
    none_sel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd3) |-> (reg_rdata == '0));

endmodule

bind mmu_xlat_ctl mmu_xlat_ctl_chk #(
    .ADDR_W (ADDR_W),
    .ALIGN  (ALIGN),
    .EN_BIT (EN_BIT),
    .PS_BIT (PS_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .root_ptr  (root_ptr),
    .xlat_en   (xlat_en),
    .page_size (page_size),
    .laddr     (laddr),
    .tt_hit    (tt_hit),
    .tt_attr   (tt_attr),
    .paddr     (paddr),
    .attr_out  (attr_out)
);

// File: tb/sim_mmu_xlat_ctl.sv
module sim_mmu_xlat_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        super_mode = 1'b0;
    logic [31:0] root_ptr;
    logic        xlat_en;
    logic        page_size;
    logic [3:0]  page_ofs_bits;
    logic [31:0] laddr = '0;
    logic        tt_hit = 1'b0;
    logic [4:0]  tt_attr = '0;
    logic [31:0] paddr;
    logic [4:0]  attr_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mmu_xlat_ctl u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_we        (reg_we),
        .reg_sel       (reg_sel),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .super_mode    (super_mode),
        .root_ptr      (root_ptr),
        .xlat_en       (xlat_en),
        .page_size     (page_size),
        .page_ofs_bits (page_ofs_bits),
        .laddr         (laddr),
        .tt_hit        (tt_hit),
        .tt_attr       (tt_attr),
        .paddr         (paddr),
        .attr_out      (attr_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] data);
        reg_sel = sel;
        #1;
        data = reg_rdata;
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        // R4: during reset
        @(negedge clk);
        check("R4 enable in reset", 32'(xlat_en), 32'd0);
        rd(2'd0, d); check("R4 user root in reset", d, 32'h0);
        rd(2'd1, d); check("R4 super root in reset", d, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_roots();
        logic [31:0] d;
        wr(2'd0, 32'hFFFF_FFFF);
        wr(2'd1, 32'hA5A5_A5A5);
        rd(2'd0, d); check("R1 user root all ones", d, 32'hFFFF_FE00);
        rd(2'd1, d); check("R1 super root pattern", d, 32'hA5A5_A400);
        super_mode = 1'b0; #1;
        check("R7 user root selected", root_ptr, 32'hFFFF_FE00);
        super_mode = 1'b1; #1;
        check("R7 super root selected", root_ptr, 32'hA5A5_A400);
        wr(2'd0, 32'h0000_01FF);
        rd(2'd0, d); check("R1 low-only write", d, 32'h0);
    endtask

    task automatic t_ctl();
        logic [31:0] d;
        wr(2'd2, 32'hFFFF_BFFF);
        rd(2'd2, d); check("R2 enable only", d, 32'h0000_8000);
        check("R3 enable set", 32'(xlat_en), 32'd1);
        check("R6 4K page size", 32'(page_size), 32'd0);
        check("R6 offset 12", 32'(page_ofs_bits), 32'd12);
        wr(2'd2, 32'h0000_7FFF);
        rd(2'd2, d); check("R2 size only", d, 32'h0000_4000);
        check("R3 enable cleared", 32'(xlat_en), 32'd0);
        check("R6 offset 13", 32'(page_ofs_bits), 32'd13);
        wr(2'd2, 32'h0000_C000);
        rd(2'd2, d); check("R2 both bits", d, 32'h0000_C000);
    endtask

    task automatic t_psize_reset();
        logic [31:0] d;
        // control currently 0xC000
        pulse_reset();
        rd(2'd2, d); check("R5 size kept, enable cleared", d, 32'h0000_4000);
        check("R5 page_size kept high", 32'(page_size), 32'd1);
        wr(2'd2, 32'h0000_0000);
        pulse_reset();
        check("R5 page_size kept low", 32'(page_size), 32'd0);
        check("R6 offset after reset", 32'(page_ofs_bits), 32'd12);
    endtask

    task automatic t_bypass();
        tt_hit = 1'b0; laddr = 32'h1234_5678; #1;
        check("R8 pass address", paddr, 32'h1234_5678);
        check("R9 default attributes", 32'(attr_out), 32'd0);
        laddr = 32'hFFFF_F000; tt_attr = 5'b10111; #1;
        check("R8 pass high address", paddr, 32'hFFFF_F000);
        check("R9 default ignores window attr", 32'(attr_out), 32'd0);
        tt_hit = 1'b1; #1;
        check("R10 window attributes", 32'(attr_out), 32'h17);
        tt_attr = 5'b01010; #1;
        check("R10 window attributes 2", 32'(attr_out), 32'h0A);
        wr(2'd2, 32'h0000_8000);
        check("R8 paged address zero", paddr, 32'h0);
        check("R10 paged attr zero", 32'(attr_out), 32'd0);
        tt_hit = 1'b0;
    endtask

    task automatic t_none_sel();
        logic [31:0] d;
        wr(2'd0, 32'h1357_9BDF);
        wr(2'd1, 32'h2468_ACE0);
        wr(2'd2, 32'h0000_4000);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, d); check("R11 unused reads zero", d, 32'h0);
        rd(2'd0, d); check("R11 user root untouched", d, 32'h1357_9A00);
        rd(2'd1, d); check("R11 super root untouched", d, 32'h2468_AC00);
        rd(2'd2, d); check("R11 control untouched", d, 32'h0000_4000);
        check("R11 enable untouched", 32'(xlat_en), 32'd0);
    endtask

    initial begin
        t_reset_state();
        t_roots();
        t_ctl();
        t_psize_reset();
        t_bypass();
        t_none_sel();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule